// File: doc/BRIEF.md
# Timer Input Capture Unit

This block holds a free-running counter twice as wide as its register bus and a capture register that takes a snapshot of the counter when an event arrives. Three sources raise an event: a rising edge on an asynchronous capture pin (after a two-flop synchroniser), a one-cycle tick strobe from a neighbouring timer in the same clock domain, and a software request bit in the control register that clears itself once it has taken effect.

Software reaches the unit over a narrow byte bus. Every wide value is read low byte first. That read also parks the matching high byte in one temporary register, and the temporary register is shared by every wide register. A later read of any high-byte address returns the parked byte, so the two halves always belong to the same snapshot. A data address is also provided: a write to it fills a transmit byte, and a read from it returns a receive byte supplied from outside the unit.

Top module: `tcu_top`

## Requirements
- R1: The counter resets to 0. It adds one on every clock where `cnt_en` is high, holds its value when `cnt_en` is low, and wraps from 0xFFFF to 0. Its low byte is read at address 4.
- R2: `cap_pin` passes through two synchronising flops. A 0-to-1 change of the synchronised level causes exactly one capture. A pin that stays high causes no further capture.
- R3: If `tick_in` is high in a cycle, the counter value of that cycle is captured at the end of that cycle.
- R4: Writing a byte with bit 0 set to address 0 sets the software request bit. At the next clock edge the counter value is captured and the bit returns to 0.
- R5: Address 0 reads {7'b0, request bit}. Bits 7 to 1 always read 0, and the register resets to 0.
- R6: If pin edge, tick and software request coincide in one cycle, one capture of that cycle's counter value takes place and the request bit is cleared.
- R7: The capture register resets to 0 and holds its value between events. Reading address 1 returns its low byte and copies its high byte into the temporary register on the same edge.
- R8: Address 2 (capture high) and address 5 (counter high) both return the temporary register. Reading address 4 copies the counter's high byte into that same temporary register.
- R9: A write to address 3 sets `tx_data`. A read of address 3 returns `rx_data`. Addresses 6 and 7 read 0.
- R10: `bus_rdata` is registered. It changes on the clock edge where `bus_rd` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Counter enable |
| cap_pin | input | 1 | Asynchronous capture pin |
| tick_in | input | 1 | One-cycle tick from the neighbouring timer |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| rx_data | input | 8 | Receive byte returned at the data address |
| bus_rdata | output | 8 | Registered read data |
| tx_data | output | 8 | Transmit byte |

## Verification
The bench uses the default parameters: an 8-bit bus, a 16-bit counter, two synchroniser stages and a 3-bit address. With a 16-bit counter, a full wrap from 0xFFFF to 0 takes about 65k enabled cycles, which fits in one run. This allows the low-then-high read across the wrap to be observed. Random interleaving of low-byte and high-byte reads over both wide registers, together with capture events fired between the two halves, exercises the sharing of the temporary register.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int ADR_CTRL = 0;
  localparam int ADR_CAPL = 1;
  localparam int ADR_CAPH = 2;
  localparam int ADR_DATA = 3;
  localparam int ADR_CNTL = 4;
  localparam int ADR_CNTH = 5;
endpackage

// File: rtl/tcu_edge_sync.sv
module tcu_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], async_in};
      last_q <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last_q;

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/tcu_counter.sv
module tcu_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end

  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == TOP) |=> cnt == '0);
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));
endmodule

// File: rtl/tcu_capture.sv
module tcu_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pin_rise,
  input  logic         tick,
  input  logic         sw_req,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] cap
);
  logic fire;
  assign fire = pin_rise | tick | sw_req;

  always_ff @(posedge clk) begin
    if (rst)       cap <= '0;
    else if (fire) cap <= cnt;
  end

  assert_cap_load_R6: assert property (@(posedge clk) disable iff (rst)
    fire |=> cap == $past(cnt));
  assert_cap_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(cap));
endmodule

// File: rtl/tcu_regbus.sv
module tcu_regbus #(
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [BUS_W-1:0]     wdata,
  input  logic [BUS_W-1:0]     rx_data,
  input  logic [2*BUS_W-1:0]   cap,
  input  logic [2*BUS_W-1:0]   cnt,
  output logic [BUS_W-1:0]     rdata,
  output logic [BUS_W-1:0]     tx_data,
  output logic                 sw_req
);
  import tcu_pkg::*;

  logic [BUS_W-1:0] temp_q;
  logic [BUS_W-1:0] rd_mux;
  logic             wr_ctrl;

  assign wr_ctrl = wr && (addr == ADDR_W'(ADR_CTRL));

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(ADR_CTRL): rd_mux = {{(BUS_W-1){1'b0}}, sw_req};
      ADDR_W'(ADR_CAPL): rd_mux = cap[BUS_W-1:0];
      ADDR_W'(ADR_CAPH): rd_mux = temp_q;
      ADDR_W'(ADR_DATA): rd_mux = rx_data;
      ADDR_W'(ADR_CNTL): rd_mux = cnt[BUS_W-1:0];
      ADDR_W'(ADR_CNTH): rd_mux = temp_q;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      temp_q  <= '0;
      tx_data <= '0;
      sw_req  <= 1'b0;
    end else begin
      if (rd) begin
        rdata <= rd_mux;
        if (addr == ADDR_W'(ADR_CAPL)) temp_q <= cap[2*BUS_W-1:BUS_W];
        if (addr == ADDR_W'(ADR_CNTL)) temp_q <= cnt[2*BUS_W-1:BUS_W];
      end
      if (wr && addr == ADDR_W'(ADR_DATA)) tx_data <= wdata;
      if (wr_ctrl)     sw_req <= wdata[0];
      else if (sw_req) sw_req <= 1'b0;
    end
  end

  assert_swbit_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (sw_req && !wr_ctrl) |=> !sw_req);
  assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == ADDR_W'(ADR_CTRL)) |=> rdata[BUS_W-1:1] == '0);
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
  assert_temp_high_R8: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == ADDR_W'(ADR_CAPL)) |=> temp_q == $past(cap[2*BUS_W-1:BUS_W]));
endmodule

// File: rtl/tcu_top.sv
module tcu_top #(
  parameter int BUS_W       = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              cap_pin,
  input  logic              tick_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [BUS_W-1:0]  rx_data,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [BUS_W-1:0]  tx_data
);
  localparam int CNT_W = 2 * BUS_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cap;
  logic             pin_rise;
  logic             sw_req;

  tcu_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(cap_pin), .rise(pin_rise)
  );

  tcu_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(cnt_en), .cnt(cnt)
  );

  tcu_capture #(.W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .pin_rise(pin_rise), .tick(tick_in),
    .sw_req(sw_req), .cnt(cnt), .cap(cap)
  );

  tcu_regbus #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .rx_data(rx_data), .cap(cap), .cnt(cnt),
    .rdata(bus_rdata), .tx_data(tx_data), .sw_req(sw_req)
  );
endmodule

// File: tb/test_tcu_top.sv
module test_tcu_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0, cap_pin = 1'b0, tick_in = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, rx_data = '0;
  logic [7:0] bus_rdata, tx_data;

  int checks = 0;
  int errors = 0;

  // reference state, derived from the requirements
  logic [15:0] m_cnt = '0, m_cap = '0;
  logic [7:0]  m_temp = '0, m_rdata = '0, m_tx = '0;
  logic        m_sw = 1'b0, m_s1 = 1'b0, m_s2 = 1'b0, m_s3 = 1'b0;

  tcu_top i_tcu_top (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cap_pin(cap_pin), .tick_in(tick_in),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .rx_data(rx_data), .bus_rdata(bus_rdata), .tx_data(tx_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; errors++;
    $display("FAIL watchdog R1 actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return "R4/R5";
      3'd1: return "R7";
      3'd2: return "R8";
      3'd3: return "R9";
      3'd4: return "R1";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {7'b0, m_sw};
      3'd1: return m_cap[7:0];
      3'd2: return m_temp;
      3'd3: return rx_data;
      3'd4: return m_cnt[7:0];
      3'd5: return m_temp;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic pin, input logic tk,
                      input logic rd, input logic wr, input logic [2:0] a,
                      input logic [7:0] wd, input logic [7:0] rx, input string tag);
    logic rise;
    @(negedge clk);
    cnt_en = en; cap_pin = pin; tick_in = tk; bus_rd = rd; bus_wr = wr;
    bus_addr = a; bus_wdata = wd; rx_data = rx;
    @(posedge clk);
    rise = m_s2 & ~m_s3;
    if (rd) begin
      m_rdata = exp_read(a);
      if (a == 3'd1) m_temp = m_cap[15:8];
      if (a == 3'd4) m_temp = m_cnt[15:8];
    end
    if (rise || tk || m_sw) m_cap = m_cnt;
    if (wr && a == 3'd0) m_sw = wd[0];
    else if (m_sw)       m_sw = 1'b0;
    if (wr && a == 3'd3) m_tx = wd;
    if (en) m_cnt = m_cnt + 16'd1;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
    #1;
    if (rd) check8((tag == "") ? req_of(a) : tag, bus_rdata, m_rdata);
    if (wr && a == 3'd3) check8("R9", tx_data, m_tx);
  endtask

  task automatic rd_reg(input logic [2:0] a, input string tag);
    step(cnt_en, cap_pin, 1'b0, 1'b1, 1'b0, a, 8'h00, rx_data, tag);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // reset values
    rd_reg(3'd0, "R5");
    rd_reg(3'd1, "R7");
    rd_reg(3'd2, "R7");
    rd_reg(3'd4, "R1");
    rd_reg(3'd5, "R1");

    // R1: counting and holding
    repeat (5) step(1, 0, 0, 0, 0, 0, 0, 0, "");
    rd_reg(3'd4, "R1");
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0, "");
    rd_reg(3'd4, "R1");

    // R2: synchronised rising edge, then a level held high
    step(1, 1, 0, 0, 0, 0, 0, 0, "");
    repeat (4) step(1, 1, 0, 0, 0, 0, 0, 0, "");
    rd_reg(3'd1, "R2");
    repeat (4) step(1, 1, 0, 0, 0, 0, 0, 0, "");
    rd_reg(3'd1, "R2");
    step(1, 0, 0, 0, 0, 0, 0, 0, "");

    // R3: tick capture
    repeat (3) step(1, 0, 0, 0, 0, 0, 0, 0, "");
    step(1, 0, 1, 0, 0, 0, 0, 0, "");
    rd_reg(3'd1, "R3");

    // R4: software request sets then clears itself
    step(1, 0, 0, 0, 1, 3'd0, 8'hFF, 0, "");
    rd_reg(3'd0, "R4");
    rd_reg(3'd1, "R4");

    // R6: three sources in one cycle
    step(1, 1, 0, 0, 0, 0, 0, 0, "");
    step(1, 1, 0, 0, 1, 3'd0, 8'h01, 0, "");
    step(1, 1, 1, 1, 0, 3'd0, 0, 0, "R6");
    rd_reg(3'd0, "R6");
    rd_reg(3'd1, "R6");
    step(1, 0, 0, 0, 0, 0, 0, 0, "");

    // R8: high byte frozen in temp while a new capture lands; shared temp
    rd_reg(3'd1, "R8");
    step(1, 0, 1, 0, 0, 0, 0, 0, "");
    rd_reg(3'd2, "R8");
    rd_reg(3'd4, "R8");
    rd_reg(3'd2, "R8");

    // R9: data address and unused addresses
    step(1, 0, 0, 0, 1, 3'd3, 8'hA5, 8'h3C, "");
    step(1, 0, 0, 1, 0, 3'd3, 0, 8'h3C, "R9");
    step(1, 0, 0, 1, 0, 3'd6, 0, 8'h3C, "R9");
    step(1, 0, 0, 1, 0, 3'd7, 0, 8'h3C, "R9");

    // R10: no read strobe leaves rdata alone
    rd_reg(3'd3, "R10");
    step(1, 0, 1, 0, 0, 3'd1, 0, 8'h77, "");
    check8("R10", bus_rdata, m_rdata);

    // constrained random traffic, fixed seed
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      logic en, tk, rd, wr;
      logic [2:0] a, wa;
      en = ($urandom_range(9) != 0);
      if ($urandom_range(7) == 0) cap_pin = ~cap_pin;
      tk = ($urandom_range(15) == 0);
      rd = $urandom_range(1);
      wr = ($urandom_range(7) == 0);
      a  = 3'($urandom_range(7));
      wa = ($urandom_range(1) != 0) ? 3'd0 : 3'd3;
      if (wr) a = rd ? a : wa;
      step(en, cap_pin, tk, rd, wr, wr && !rd ? wa : a, 8'($urandom), 8'($urandom), "");
    end

    // R1: wrap from 0xFFFF to 0, read low then high across it
    while (m_cnt != 16'hFFFF) step(1, 0, 0, 0, 0, 0, 0, 0, "");
    rd_reg(3'd4, "R1");
    rd_reg(3'd5, "R1");
    rd_reg(3'd4, "R1");
    rd_reg(3'd5, "R1");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule